// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block turns a set of parallel per-channel audio words into a time-division multiplexed serial stream. An external bit clock and frame sync, produced by the bus master, set the timing. Both are sampled in a single fast system clock domain, so the system clock must run at least four times faster than the bit clock. When the block sees a frame-sync rising edge, it latches one word per channel. It then sends the active slots in ascending channel order, MSB first.

The launch of the first bit can be delayed by a programmable number of bit clocks after the frame-sync edge. The bit-clock polarity can be inverted. The frame-sync pulse may be one or several bit clocks wide. Bit clocks after the last active slot are idle, and the data line is released during them. A frame that is cut short by an early frame sync raises an error pulse, and transmission restarts at slot 0. A one-cycle ready pulse tells upstream logic that the input words have been captured and new ones may be loaded.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While reset is asserted and after its release, before any frame starts, `sdout`, `sdout_oe`, `short_frame_err` and `sample_ready` are low.
- R2: A frame starts when frame sync is sampled high at a capture (non-launch) bit-clock edge after being sampled low at the previous capture edge. Frame-sync pulses of any width start exactly one frame.
- R3: Bit-clock period n of a frame carries data index n minus `cfg_offset`. Period 0 is the period in which frame sync first goes high. With offset 0, the slot 0 MSB is driven as soon as the frame start is detected. With offset N greater than 0, it is driven at the Nth launch edge after that.
- R4: Word length codes are 0 for 16 bits, 1 for 20, 2 for 24 and 3 for 32. Slot s, bit k (k = 0 is first) carries bit 31-k of channel s's word, so each word is left-aligned and sent MSB first. Slots 0 to `cfg_nch`-1 follow back to back. Channel c is taken from `samples_in[32*c +: 32]`.
- R5: Data bits change only on launch edges: the rising bit-clock edge when `cfg_bclk_inv` is 0. The one exception is the offset-0 MSB of slot 0.
- R6: While no data bit is being sent (offset periods, idle periods, between frames), `sdout` and `sdout_oe` are 0. During data bits `sdout_oe` is 1.
- R7: Channel words are latched at frame start, and later changes on `samples_in` do not affect that frame. `sample_ready` pulses for one system clock, one clock after the frame start.
- R8: A frame start that arrives before the last data bit of the previous frame has completed causes a one-cycle `short_frame_err` pulse. The new frame then runs correctly from slot 0.
- R9: A new frame sync may arrive in the period right after the last data bit. Such back-to-back frames are sent without error.
- R10: With `cfg_bclk_inv` = 1, the falling bit-clock edge launches data and the rising edge samples frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Bit clock from the bus master (asynchronous) |
| fsync_in | input | 1 | Frame sync from the bus master (asynchronous) |
| cfg_wlen | input | 2 | Slot word length code |
| cfg_nch | input | 3 | Number of active slots, 1 to NCH_MAX |
| cfg_offset | input | OFS_W | Launch delay of the slot 0 MSB, in bit clocks |
| cfg_bclk_inv | input | 1 | Swap launch and capture bit-clock edges |
| samples_in | input | NCH_MAX*32 | Per-channel words, channel 0 in the low bits |
| sample_ready | output | 1 | One-cycle pulse when the words have been latched |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | High while a data bit is driven |
| short_frame_err | output | 1 | One-cycle pulse on a frame cut short |

## Verification
The bench runs frames over every word length, several slot counts, offsets of 0, small values and the maximum, both bit-clock polarities, and single and multi-period frame-sync pulses. Offset 0 against nonzero offsets shows whether the MSB goes out at detection or at a launch edge. Frames with idle periods against back-to-back frames show whether the block ends a frame cleanly and accepts an immediate restart. Corrupting `samples_in` after frame start shows whether the words are latched. A directed frame cut off after ten bits separates error reporting from a clean restart.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  // Width of one slot in bit clocks for a word length code.
  function automatic int unsigned slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_sync2.sv
module tdm_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tdm_edge_det.sv
module tdm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic bclk_inv,
  output logic launch_edge,
  output logic frame_start
);
  logic bclk_s, fsync_s, bclk_d, fs_held;
  logic lvl_now, lvl_prev, capture_edge;

  tdm_sync2 #(.STAGES(2)) u_sync_bclk (.clk(clk), .rst_n(rst_n), .d(bclk_in),  .q(bclk_s));
  tdm_sync2 #(.STAGES(2)) u_sync_fs   (.clk(clk), .rst_n(rst_n), .d(fsync_in), .q(fsync_s));

  // Normalised level: high half is the launch phase.
  assign lvl_now      = bclk_s ^ bclk_inv;
  assign lvl_prev     = bclk_d ^ bclk_inv;
  assign launch_edge  = lvl_now & ~lvl_prev;
  assign capture_edge = ~lvl_now & lvl_prev;
  assign frame_start  = capture_edge & fsync_s & ~fs_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      fs_held <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (capture_edge) fs_held <= fsync_s;
    end
  end

  // R2: a wide frame-sync pulse yields a single start event
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_tx_pkg::*;
#(
  parameter int NCH_MAX = 4,
  parameter int SAMP_W  = 32,
  parameter int OFS_W   = 4,
  localparam int SLOT_W = (NCH_MAX > 1) ? $clog2(NCH_MAX) : 1,
  localparam int BIT_W  = $clog2(SAMP_W),
  localparam int NCH_W  = $clog2(NCH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_edge,
  input  logic              frame_start,
  input  logic [1:0]        cfg_wlen,
  input  logic [NCH_W-1:0]  cfg_nch,
  input  logic [OFS_W-1:0]  cfg_offset,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              shifting,
  output logic              short_err
);
  tx_state_e         state;
  logic [OFS_W-1:0]  ofs_left;
  logic [BIT_W-1:0]  wl_m1;
  logic [SLOT_W-1:0] last_slot;
  logic              slot_end, frame_end;

  assign wl_m1     = BIT_W'(slot_bits(cfg_wlen) - 1);
  assign last_slot = (cfg_nch == '0) ? '0 : SLOT_W'(cfg_nch - NCH_W'(1));
  assign slot_end  = (bit_idx == wl_m1);
  assign frame_end = slot_end && (slot_idx == last_slot);
  assign shifting  = (state == TX_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      ofs_left  <= '0;
      slot_idx  <= '0;
      bit_idx   <= '0;
      short_err <= 1'b0;
    end else begin
      short_err <= frame_start && (state != TX_IDLE);
      if (frame_start) begin
        slot_idx <= '0;
        bit_idx  <= '0;
        ofs_left <= cfg_offset;
        state    <= (cfg_offset == '0) ? TX_SHIFT : TX_WAIT;
      end else if (launch_edge) begin
        case (state)
          TX_WAIT: begin
            if (ofs_left <= OFS_W'(1)) state <= TX_SHIFT;
            else                       ofs_left <= ofs_left - OFS_W'(1);
          end
          TX_SHIFT: begin
            if (slot_end) begin
              bit_idx <= '0;
              if (frame_end) state <= TX_IDLE;
              else           slot_idx <= slot_idx + SLOT_W'(1);
            end else begin
              bit_idx <= bit_idx + BIT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: zero offset drives immediately, nonzero offset waits
  a_r3_zero_offset_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_offset == '0) |=> shifting);
  a_r3_offset_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_offset != '0) |=> (state == TX_WAIT));
  // R4: counters stay inside the configured frame
  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (slot_idx <= last_slot));
  a_r4_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (bit_idx <= wl_m1));
  // R5: bit position moves only on a launch edge or a restart
  a_r5_moves_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_idx) |-> $past(launch_edge || frame_start));
  // R8: error pulse only follows a frame start
  a_r8_err_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> $past(frame_start));
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int NCH_MAX = 4,
  parameter int OFS_W   = 4,
  localparam int SAMP_W = 32,
  localparam int SLOT_W = (NCH_MAX > 1) ? $clog2(NCH_MAX) : 1,
  localparam int BIT_W  = $clog2(SAMP_W),
  localparam int NCH_W  = $clog2(NCH_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bclk_in,
  input  logic                      fsync_in,
  input  logic [1:0]                cfg_wlen,
  input  logic [NCH_W-1:0]          cfg_nch,
  input  logic [OFS_W-1:0]          cfg_offset,
  input  logic                      cfg_bclk_inv,
  input  logic [NCH_MAX*SAMP_W-1:0] samples_in,
  output logic                      sample_ready,
  output logic                      sdout,
  output logic                      sdout_oe,
  output logic                      short_frame_err
);
  logic              launch_edge, frame_start, shifting;
  logic [SLOT_W-1:0] slot_idx;
  logic [BIT_W-1:0]  bit_idx, bit_sel;
  logic [SAMP_W-1:0] word_q [NCH_MAX];

  tdm_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .bclk_inv(cfg_bclk_inv), .launch_edge(launch_edge), .frame_start(frame_start)
  );

  tdm_slot_seq #(.NCH_MAX(NCH_MAX), .SAMP_W(SAMP_W), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch_edge(launch_edge), .frame_start(frame_start),
    .cfg_wlen(cfg_wlen), .cfg_nch(cfg_nch), .cfg_offset(cfg_offset),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .shifting(shifting), .short_err(short_frame_err)
  );

  for (genvar ch = 0; ch < NCH_MAX; ch++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q[ch] <= '0;
      else if (frame_start) word_q[ch] <= samples_in[ch*SAMP_W +: SAMP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_ready <= 1'b0;
    else        sample_ready <= frame_start;
  end

  // Left-aligned, MSB first.
  assign bit_sel  = BIT_W'(SAMP_W - 1) - bit_idx;
  assign sdout    = shifting ? word_q[slot_idx][bit_sel] : 1'b0;
  assign sdout_oe = shifting;

  // R7: ready follows each frame start and lasts one cycle
  a_r7_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sample_ready);
  a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ready |=> !sample_ready);
endmodule

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;
  localparam int NCH = 4;
  localparam int OW  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0, inv = 1'b0;
  logic [1:0] wlen = '0;
  logic [2:0] nch = 3'd1;
  logic [OW-1:0] ofs = '0;
  logic [NCH*32-1:0] samples = '0;
  logic ready, sdout, oe, err;

  tdm_tx_serializer #(.NCH_MAX(NCH), .OFS_W(OW)) u_tdm_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fsync),
    .cfg_wlen(wlen), .cfg_nch(nch), .cfg_offset(ofs), .cfg_bclk_inv(inv),
    .samples_in(samples), .sample_ready(ready), .sdout(sdout),
    .sdout_oe(oe), .short_frame_err(err)
  );

  int checks = 0, errors = 0, err_pulses = 0, rdy_pulses = 0;

  always @(posedge clk) if (rst_n) begin
    if (err)   err_pulses++;
    if (ready) rdy_pulses++;
  end

  // columns: wlen code, channels, offset, inverted, fsync width, idle periods
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{0, 2, 0, 0, 1, 3},
    '{1, 3, 1, 0, 1, 2},
    '{2, 4, 2, 0, 3, 0},
    '{3, 4, 0, 0, 1, 0},
    '{0, 4, 0, 1, 1, 1},
    '{2, 1, 5, 1, 2, 4},
    '{3, 1, 15, 0, 4, 2},
    '{1, 4, 3, 0, 1, 0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input int code);
    return 16 + 4 * code + ((code == 3) ? 4 : 0);
  endfunction

  function automatic logic [31:0] word_of(input int vi, input int fr, input int ch);
    return (32'h9E3779B9 * (vi * 16 + fr * 4 + ch + 1)) ^ 32'h5A5AC3C3;
  endfunction

  // One bit-clock period: launch half then capture half, sample at its end.
  task automatic bit_period(input logic fs, output logic sd, output logic en);
    @(negedge clk);
    bclk  = inv ? 1'b0 : 1'b1;
    fsync = fs;
    repeat (4) @(negedge clk);
    bclk = inv ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
    sd = sdout;
    en = oe;
  endtask

  task automatic run_frame(input int vi, input int fr, input int fsw, input int nper);
    logic sd, en;
    int wl = wbits(int'(wlen));
    for (int c = 0; c < NCH; c++) samples[c*32 +: 32] = word_of(vi, fr, c);
    for (int p = 0; p < nper; p++) begin
      bit_period(p < fsw, sd, en);
      if (p == 1) samples = ~samples; // R7: must not reach this frame
      begin
        int idx = p - int'(ofs);
        if (idx >= 0 && idx < int'(nch) * wl) begin
          logic [31:0] w = word_of(vi, fr, idx / wl);
          chk("R3 R4 R5 R7 data bit", {31'b0, sd}, {31'b0, w[31 - (idx % wl)]});
          chk("R6 oe during data", {31'b0, en}, 32'd1);
        end else begin
          chk("R6 idle sdout", {31'b0, sd}, 32'd0);
          chk("R6 idle oe", {31'b0, en}, 32'd0);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic sd, en;
    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 sdout in reset", {31'b0, sdout}, 32'd0);
    chk("R1 oe in reset", {31'b0, oe}, 32'd0);
    chk("R1 err in reset", {31'b0, err}, 32'd0);
    chk("R1 ready in reset", {31'b0, ready}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      bit_period(1'b0, sd, en);
      chk("R1 oe idle after reset", {31'b0, en}, 32'd0);
      chk("R1 ready idle after reset", ready_count_zero(), 32'd0);
    end

    for (int v = 0; v < NV; v++) begin
      int e0, r0, len;
      wlen = 2'(VEC[v][0]);
      nch  = 3'(VEC[v][1]);
      ofs  = OW'(VEC[v][2]);
      inv  = VEC[v][3][0]; // R10 when set
      bit_period(1'b0, sd, en);
      chk("R6 settle idle", {31'b0, en}, 32'd0);
      e0 = err_pulses;
      r0 = rdy_pulses;
      len = VEC[v][2] + VEC[v][1] * wbits(VEC[v][0]) + VEC[v][5];
      run_frame(v, 0, VEC[v][4], len);
      run_frame(v, 1, VEC[v][4], len); // R9 when idle count is 0
      for (int i = 0; i < 2; i++) begin
        bit_period(1'b0, sd, en);
        chk("R6 flush idle", {31'b0, en}, 32'd0);
      end
      chk("R9 R10 no short-frame error", 32'(err_pulses - e0), 32'd0);
      chk("R2 R7 one ready per frame", 32'(rdy_pulses - r0), 32'd2);
    end

    // R8: frame cut off after ten bits, then a clean full frame
    wlen = 2'd0; nch = 3'd4; ofs = '0; inv = 1'b0;
    bit_period(1'b0, sd, en);
    begin
      int e0 = err_pulses;
      run_frame(20, 0, 1, 10);
      run_frame(21, 0, 1, 64 + 1);
      chk("R8 short-frame error pulse", 32'(err_pulses - e0), 32'd1);
    end
    bit_period(1'b0, sd, en);
    chk("R8 line idle after restart frame", {31'b0, en}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] ready_count_zero();
    return 32'(rdy_pulses);
  endfunction
endmodule